// File: doc/BRIEF.md
# Prefix-and-Opcode Byte Classifier

This block sits at the front of an instruction decoder for a 16-bit processor with segment registers. It takes instruction bytes one at a time, qualified by a valid strobe. Prefix bytes (segment override, bus lock, string repeat) are collected over as many cycles as they arrive. The first byte that is not a prefix is classified in a single step. The result gives an operation code and a source and a destination selector. It also gives the operand size in bytes and the phase that must follow. That phase says whether the instruction is already complete, still needs a ModR/M byte, or still needs a known number of displacement and immediate bytes.

The result is posted with a one-cycle strobe, together with the latched prefixes and the number of bytes used so far. Decoding the ModR/M byte and collecting the trailing bytes belong to later stages. For those stages the block hands over the byte counts and then stands aside. Until a later stage signals that it is finished, the classifier takes no further bytes. The operation and selector codes are the enumerations `op_e` and `sel_e` in `opc_pkg`.

Top module: `opc_classifier`

## Requirements
- R1: After reset `out_valid` is 0, `out_op` is OP_NONE, `out_consumed`, `out_seg`, `out_lock` and `out_rep` are 0, and the block is ready, so `byte_taken` equals `in_valid`.
- R2: Prefix bytes are latched and reported with the next opcode: 0x26/0x2E/0x36/0x3E give `out_seg` 1/2/3/4 (ES/CS/SS/DS), 0xF0 gives `out_lock`=1, 0xF2 gives `out_rep`=1 and 0xF3 gives `out_rep`=2. A later prefix of the same kind replaces an earlier one.
- R3: For opcodes 0x00–0x3F whose low three bits are 0–5, bits [5:3] select ADD, OR, ADC, SBB, AND, SUB, XOR, CMP. Low bits 0–3 need ModR/M, with bit0 giving a word (2) or byte (1) size and bit1=1 meaning the register field is the destination. Low bit 4 is AL with a 1-byte immediate, and 5 is AX with a 2-byte immediate.
- R4: Opcodes 0x40–0x5F are complete single-byte INC, DEC, PUSH and POP (in blocks of eight) of size 2, on register AX, CX, DX, BX, SP, BP, SI, DI selected by bits [2:0].
- R5: 0x70–0x7F (OP_JO plus the low nibble), 0xE0–0xE3 and 0xEB need exactly one displacement byte and no immediate. 0xE8 and 0xE9 need two displacement bytes.
- R6: 0x9A (far call) and 0xEA (far jump) need a 4-byte immediate, no displacement and no ModR/M.
- R7: 0xB0–0xB7 move a 1-byte immediate into AL, CL, DL, BL, AH, CH, DH, BH. 0xB8–0xBF move a 2-byte immediate into the word registers in R4 order.
- R8: 0xD0–0xD3 are the shift group and need ModR/M, with bit0 selecting word size. 0xD0/0xD1 have source SEL_ONE and 0xD2/0xD3 have source SEL_CL.
- R9: An unassigned opcode posts `out_invalid`=1, OP_NONE, phase 0 and zero counts. `out_consumed` includes the prefixes and the bad byte.
- R10: After any post, the latched prefixes and the byte count are cleared before the next byte.
- R11: While a posted instruction still needs ModR/M or trailing bytes, `byte_taken` is 0 and incoming bytes have no effect until `follow_done` is pulsed.
- R12: `out_valid` pulses in the cycle after the opcode byte is taken. The result fields then hold until the next post. `out_consumed` counts prefixes plus the opcode and saturates at 2^CNT_W-1.
- R13: `out_phase` is 0 for complete, 1 when ModR/M is needed (displacement then reported as 0), and 2 when only displacement or immediate bytes follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction byte present |
| in_byte | input | 8 | Instruction byte |
| follow_done | input | 1 | Later stage finished with the current instruction |
| byte_taken | output | 1 | Byte consumed by this block this cycle |
| out_valid | output | 1 | One-cycle post strobe |
| out_invalid | output | 1 | Posted opcode is unassigned |
| out_op | output | 7 | Operation code (op_e) |
| out_src | output | 5 | Source selector (sel_e) |
| out_dst | output | 5 | Destination selector (sel_e) |
| out_size | output | 3 | Operation size in bytes (0, 1, 2, 4) |
| out_phase | output | 2 | Follow-on phase |
| out_disp_bytes | output | 2 | Displacement bytes still required |
| out_imm_bytes | output | 3 | Immediate bytes still required |
| out_seg | output | 3 | Segment override |
| out_lock | output | 1 | Lock prefix seen |
| out_rep | output | 2 | Repeat prefix |
| out_consumed | output | CNT_W | Bytes consumed for this instruction |

## Verification
The stimulus includes bare opcodes from every family: the ALU blocks in all three operand shapes, the register blocks, short and long branches, far transfers, immediate moves and the shift pair. These show that bit fields are sliced into the right selector and count. Prefix chains are tested with and without repeats of the same kind. They show that the last prefix of a kind wins and that nothing carries over into the next instruction. Bytes are also sent while the block is waiting on a ModR/M hand-off, followed by a clean opcode, which separates a block that really ignores them from one that latches them. A long prefix run and an invalid byte after a prefix test the count saturation and the invalid report.

// File: rtl/opc_pkg.sv
// Shared types for the prefix/opcode classifier.
// Assumes enumerations are numbered in declaration order; several
// decode paths add a small bit-field offset to a base member.
package opc_pkg;

    localparam int BYTE_W = 8;
    localparam int OP_W   = 7;
    localparam int SEL_W  = 5;
    localparam int SIZE_W = 3;
    localparam int DISP_W = 2;
    localparam int IMM_W  = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NONE,
        OP_ADD, OP_OR, OP_ADC, OP_SBB, OP_AND, OP_SUB, OP_XOR, OP_CMP,
        OP_INC, OP_DEC, OP_PUSH, OP_POP,
        OP_DAA, OP_DAS, OP_AAA, OP_AAS,
        OP_JO, OP_JNO, OP_JB, OP_JNB, OP_JE, OP_JNE, OP_JBE, OP_JA,
        OP_JS, OP_JNS, OP_JP, OP_JNP, OP_JL, OP_JGE, OP_JLE, OP_JG,
        OP_LOOPNZ, OP_LOOPZ, OP_LOOP, OP_JCXZ,
        OP_TEST, OP_XCHG, OP_MOV, OP_LEA, OP_NOP, OP_CBW, OP_CWD,
        OP_CALLF, OP_WAIT, OP_PUSHF, OP_POPF, OP_SAHF, OP_LAHF,
        OP_MOVS, OP_CMPS, OP_STOS, OP_LODS, OP_SCAS,
        OP_RETN, OP_RETF, OP_LES, OP_LDS, OP_INT3, OP_INT, OP_INTO, OP_IRET,
        OP_AAM, OP_AAD, OP_XLAT, OP_ESC, OP_IN, OP_OUT,
        OP_CALLN, OP_JMPN, OP_JMPF, OP_HLT, OP_CMC,
        OP_CLC, OP_STC, OP_CLI, OP_STI, OP_CLD, OP_STD,
        OP_GRP_ALU, OP_GRP_SHIFT, OP_GRP_UNARY, OP_GRP_INCDEC, OP_GRP_MISC
    } op_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_NONE,
        SEL_AL, SEL_CL, SEL_DL, SEL_BL, SEL_AH, SEL_CH, SEL_DH, SEL_BH,
        SEL_AX, SEL_CX, SEL_DX, SEL_BX, SEL_SP, SEL_BP, SEL_SI, SEL_DI,
        SEL_ES, SEL_CS, SEL_SS, SEL_DS,
        SEL_IMM, SEL_MEM, SEL_RM, SEL_REG, SEL_SEGREG, SEL_ONE
    } sel_e;

    typedef enum logic [1:0] {PH_DONE, PH_MODRM, PH_TAIL} phase_e;
    typedef enum logic [2:0] {SEG_NONE, SEG_ES, SEG_CS, SEG_SS, SEG_DS} seg_e;
    typedef enum logic [1:0] {REP_NONE, REP_NE, REP_E} rep_e;

    typedef struct packed {
        op_e               op;
        sel_e              src;
        sel_e              dst;
        logic [SIZE_W-1:0] size;
        phase_e            phase;
        logic [DISP_W-1:0] disp;
        logic [IMM_W-1:0]  imm;
        logic              invalid;
    } dec_t;

    // Operation code at a bit-field offset from a base member.
    function automatic op_e op_at(op_e base, logic [3:0] ofs);
        return op_e'(OP_W'(base) + OP_W'(ofs));
    endfunction

    // Selector at a bit-field offset from a base member.
    function automatic sel_e sel_at(sel_e base, logic [3:0] ofs);
        return sel_e'(SEL_W'(base) + SEL_W'(ofs));
    endfunction

endpackage

// File: rtl/opc_prefix_latch.sv
// Holds the prefix state of the instruction being assembled.
// Assumes load and clear strobes are never asserted together for the
// same field; clear wins if they are.
module opc_prefix_latch
    import opc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic ld_seg_i,
    input  logic ld_lock_i,
    input  logic ld_rep_i,
    input  seg_e seg_i,
    input  rep_e rep_i,
    output seg_e seg_o,
    output logic lock_o,
    output rep_e rep_o
);

    // Latch or clear each prefix kind; a newer prefix of a kind replaces the old.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            seg_o  <= SEG_NONE;
            lock_o <= 1'b0;
            rep_o  <= REP_NONE;
        end else begin
            if (ld_seg_i)  seg_o  <= seg_i;
            if (ld_lock_i) lock_o <= 1'b1;
            if (ld_rep_i)  rep_o  <= rep_i;
        end
    end

endmodule

// File: rtl/opc_byte_count.sv
// Saturating count of bytes taken for the current instruction.
// Assumes inc and clear are exclusive; next_o is the saturated count
// that includes the byte being taken now.
module opc_byte_count #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] next_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // Saturated successor of the stored count.
    always_comb begin
        next_o = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
    end

    // Advance on a prefix, return to zero when the instruction posts.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) cnt_q <= '0;
        else if (inc_i)        cnt_q <= next_o;
    end

endmodule

// File: rtl/opc_decode_table.sv
// Combinational classification of one byte: either a prefix (kind and
// value) or an opcode (operation, selectors, size, follow-on counts).
// Assumes displacement that depends on ModR/M is resolved downstream,
// so ModR/M opcodes report only the immediate count known from the opcode.
module opc_decode_table
    import opc_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output dec_t              dec_o,
    output logic              pfx_o,
    output logic              pfx_seg_o,
    output logic              pfx_lock_o,
    output logic              pfx_rep_o,
    output seg_e              seg_o,
    output rep_e              rep_o
);

    localparam logic [SIZE_W-1:0] SZ_NONE = 3'd0;
    localparam logic [SIZE_W-1:0] SZ_BYTE = 3'd1;
    localparam logic [SIZE_W-1:0] SZ_WORD = 3'd2;
    localparam logic [SIZE_W-1:0] SZ_FAR  = 3'd4;

    dec_t              d;
    logic              bad;
    logic [SIZE_W-1:0] wsz;
    sel_e              acc;
    logic [3:0]        r8;
    logic [3:0]        sg;

    // Classify the byte into prefix or opcode fields.
    always_comb begin
        d          = '0;
        d.op       = OP_NONE;
        d.src      = SEL_NONE;
        d.dst      = SEL_NONE;
        d.phase    = PH_DONE;
        bad        = 1'b0;
        pfx_seg_o  = 1'b0;
        pfx_lock_o = 1'b0;
        pfx_rep_o  = 1'b0;
        seg_o      = SEG_NONE;
        rep_o      = REP_NONE;
        wsz        = byte_i[0] ? SZ_WORD : SZ_BYTE;
        acc        = byte_i[0] ? SEL_AX : SEL_AL;
        r8         = {1'b0, byte_i[2:0]};
        sg         = {2'b00, byte_i[4:3]};

        case (byte_i) inside
            [8'h00:8'h3F]: begin
                case (byte_i[2:0])
                    3'd0, 3'd1, 3'd2, 3'd3: begin
                        d.op    = op_at(OP_ADD, {1'b0, byte_i[5:3]});
                        d.size  = wsz;
                        d.phase = PH_MODRM;
                        d.src   = byte_i[1] ? SEL_RM  : SEL_REG;
                        d.dst   = byte_i[1] ? SEL_REG : SEL_RM;
                    end
                    3'd4: begin
                        d.op   = op_at(OP_ADD, {1'b0, byte_i[5:3]});
                        d.src  = SEL_IMM;
                        d.dst  = SEL_AL;
                        d.size = SZ_BYTE;
                        d.imm  = 3'd1;
                    end
                    3'd5: begin
                        d.op   = op_at(OP_ADD, {1'b0, byte_i[5:3]});
                        d.src  = SEL_IMM;
                        d.dst  = SEL_AX;
                        d.size = SZ_WORD;
                        d.imm  = 3'd2;
                    end
                    3'd6: begin
                        if (!byte_i[5]) begin
                            d.op   = OP_PUSH;
                            d.src  = sel_at(SEL_ES, sg);
                            d.size = SZ_WORD;
                        end else begin
                            pfx_seg_o = 1'b1;
                            seg_o     = seg_e'(3'(sg) + 3'd1);
                        end
                    end
                    default: begin
                        if (!byte_i[5]) begin
                            if (byte_i[4:3] == 2'b01) begin
                                bad = 1'b1;
                            end else begin
                                d.op   = OP_POP;
                                d.dst  = sel_at(SEL_ES, sg);
                                d.size = SZ_WORD;
                            end
                        end else begin
                            d.op   = op_at(OP_DAA, sg);
                            d.src  = SEL_AL;
                            d.dst  = byte_i[4] ? SEL_AX : SEL_AL;
                            d.size = SZ_BYTE;
                        end
                    end
                endcase
            end
            [8'h40:8'h5F]: begin
                d.op   = op_at(OP_INC, sg);
                d.src  = sel_at(SEL_AX, r8);
                d.dst  = sel_at(SEL_AX, r8);
                d.size = SZ_WORD;
            end
            [8'h70:8'h7F]: begin
                d.op   = op_at(OP_JO, byte_i[3:0]);
                d.disp = 2'd1;
            end
            [8'h80:8'h83]: begin
                d.op    = OP_GRP_ALU;
                d.src   = SEL_IMM;
                d.dst   = SEL_RM;
                d.size  = wsz;
                d.phase = PH_MODRM;
                d.imm   = (byte_i[1:0] == 2'b01) ? 3'd2 : 3'd1;
            end
            [8'h84:8'h87]: begin
                d.op    = byte_i[1] ? OP_XCHG : OP_TEST;
                d.src   = byte_i[1] ? SEL_RM  : SEL_REG;
                d.dst   = byte_i[1] ? SEL_REG : SEL_RM;
                d.size  = wsz;
                d.phase = PH_MODRM;
            end
            [8'h88:8'h8B]: begin
                d.op    = OP_MOV;
                d.src   = byte_i[1] ? SEL_RM  : SEL_REG;
                d.dst   = byte_i[1] ? SEL_REG : SEL_RM;
                d.size  = wsz;
                d.phase = PH_MODRM;
            end
            8'h8D: begin
                d.op    = OP_LEA;
                d.src   = SEL_RM;
                d.dst   = SEL_REG;
                d.size  = SZ_WORD;
                d.phase = PH_MODRM;
            end
            8'h8E: begin
                d.op    = OP_MOV;
                d.src   = SEL_RM;
                d.dst   = SEL_SEGREG;
                d.size  = SZ_WORD;
                d.phase = PH_MODRM;
            end
            8'h8F: begin
                d.op    = OP_POP;
                d.src   = SEL_RM;
                d.dst   = SEL_RM;
                d.size  = SZ_WORD;
                d.phase = PH_MODRM;
            end
            8'h90: d.op = OP_NOP;
            [8'h91:8'h97]: begin
                d.op   = OP_XCHG;
                d.src  = SEL_AX;
                d.dst  = sel_at(SEL_AX, r8);
                d.size = SZ_WORD;
            end
            8'h98: begin
                d.op   = OP_CBW;
                d.src  = SEL_AL;
                d.dst  = SEL_AH;
                d.size = SZ_BYTE;
            end
            8'h99: begin
                d.op   = OP_CWD;
                d.src  = SEL_AX;
                d.dst  = SEL_DX;
                d.size = SZ_WORD;
            end
            8'h9A, 8'hEA: begin
                d.op   = byte_i[7:5] == 3'b100 ? OP_CALLF : OP_JMPF;
                d.src  = SEL_IMM;
                d.size = SZ_FAR;
                d.imm  = 3'd4;
            end
            8'h9B: d.op = OP_WAIT;
            8'h9C, 8'h9D: begin
                d.op   = byte_i[0] ? OP_POPF : OP_PUSHF;
                d.size = SZ_WORD;
            end
            8'h9E, 8'h9F: begin
                d.op   = byte_i[0] ? OP_LAHF : OP_SAHF;
                d.size = SZ_BYTE;
            end
            [8'hA0:8'hA3]: begin
                d.op   = OP_MOV;
                d.src  = byte_i[1] ? acc : SEL_MEM;
                d.dst  = byte_i[1] ? SEL_MEM : acc;
                d.size = wsz;
                d.disp = 2'd2;
            end
            8'hA8, 8'hA9: begin
                d.op   = OP_TEST;
                d.src  = SEL_IMM;
                d.dst  = acc;
                d.size = wsz;
                d.imm  = byte_i[0] ? 3'd2 : 3'd1;
            end
            [8'hA4:8'hAF]: begin
                d.size = wsz;
                case (byte_i[3:1])
                    3'b010:  d.op = OP_MOVS;
                    3'b011:  d.op = OP_CMPS;
                    3'b101:  d.op = OP_STOS;
                    3'b110:  d.op = OP_LODS;
                    default: d.op = OP_SCAS;
                endcase
            end
            [8'hB0:8'hBF]: begin
                d.op   = OP_MOV;
                d.src  = SEL_IMM;
                d.dst  = byte_i[3] ? sel_at(SEL_AX, r8) : sel_at(SEL_AL, r8);
                d.size = byte_i[3] ? SZ_WORD : SZ_BYTE;
                d.imm  = byte_i[3] ? 3'd2 : 3'd1;
            end
            8'hC2, 8'hC3: begin
                d.op   = OP_RETN;
                d.size = SZ_WORD;
                d.src  = byte_i[0] ? SEL_NONE : SEL_IMM;
                d.imm  = byte_i[0] ? 3'd0 : 3'd2;
            end
            8'hC4, 8'hC5: begin
                d.op    = byte_i[0] ? OP_LDS : OP_LES;
                d.src   = SEL_RM;
                d.dst   = SEL_REG;
                d.size  = SZ_WORD;
                d.phase = PH_MODRM;
            end
            8'hC6, 8'hC7: begin
                d.op    = OP_MOV;
                d.src   = SEL_IMM;
                d.dst   = SEL_RM;
                d.size  = wsz;
                d.imm   = byte_i[0] ? 3'd2 : 3'd1;
                d.phase = PH_MODRM;
            end
            8'hCA, 8'hCB: begin
                d.op   = OP_RETF;
                d.size = SZ_FAR;
                d.src  = byte_i[0] ? SEL_NONE : SEL_IMM;
                d.imm  = byte_i[0] ? 3'd0 : 3'd2;
            end
            8'hCC: d.op = OP_INT3;
            8'hCD: begin
                d.op   = OP_INT;
                d.src  = SEL_IMM;
                d.size = SZ_BYTE;
                d.imm  = 3'd1;
            end
            8'hCE: d.op = OP_INTO;
            8'hCF: d.op = OP_IRET;
            [8'hD0:8'hD3]: begin
                d.op    = OP_GRP_SHIFT;
                d.src   = byte_i[1] ? SEL_CL : SEL_ONE;
                d.dst   = SEL_RM;
                d.size  = wsz;
                d.phase = PH_MODRM;
            end
            8'hD4, 8'hD5: begin
                d.op   = byte_i[0] ? OP_AAD : OP_AAM;
                d.src  = SEL_IMM;
                d.dst  = SEL_AX;
                d.size = SZ_BYTE;
                d.imm  = 3'd1;
            end
            8'hD7: begin
                d.op   = OP_XLAT;
                d.dst  = SEL_AL;
                d.size = SZ_BYTE;
            end
            [8'hD8:8'hDF]: begin
                d.op    = OP_ESC;
                d.src   = SEL_REG;
                d.dst   = SEL_RM;
                d.phase = PH_MODRM;
            end
            [8'hE0:8'hE3]: begin
                d.op   = op_at(OP_LOOPNZ, {2'b00, byte_i[1:0]});
                d.disp = 2'd1;
            end
            [8'hE4:8'hE7]: begin
                d.op   = byte_i[1] ? OP_OUT : OP_IN;
                d.src  = byte_i[1] ? acc : SEL_IMM;
                d.dst  = byte_i[1] ? SEL_IMM : acc;
                d.size = wsz;
                d.imm  = 3'd1;
            end
            8'hE8, 8'hE9: begin
                d.op   = byte_i[0] ? OP_JMPN : OP_CALLN;
                d.size = SZ_WORD;
                d.disp = 2'd2;
            end
            8'hEB: begin
                d.op   = OP_JMPN;
                d.disp = 2'd1;
            end
            [8'hEC:8'hEF]: begin
                d.op   = byte_i[1] ? OP_OUT : OP_IN;
                d.src  = byte_i[1] ? acc : SEL_DX;
                d.dst  = byte_i[1] ? SEL_DX : acc;
                d.size = wsz;
            end
            8'hF0: pfx_lock_o = 1'b1;
            8'hF2, 8'hF3: begin
                pfx_rep_o = 1'b1;
                rep_o     = byte_i[0] ? REP_E : REP_NE;
            end
            8'hF4: d.op = OP_HLT;
            8'hF5: d.op = OP_CMC;
            8'hF6, 8'hF7: begin
                d.op    = OP_GRP_UNARY;
                d.src   = SEL_RM;
                d.dst   = SEL_RM;
                d.size  = wsz;
                d.phase = PH_MODRM;
            end
            [8'hF8:8'hFD]: d.op = op_at(OP_CLC, r8);
            8'hFE, 8'hFF: begin
                d.op    = byte_i[0] ? OP_GRP_MISC : OP_GRP_INCDEC;
                d.src   = SEL_RM;
                d.dst   = SEL_RM;
                d.size  = wsz;
                d.phase = PH_MODRM;
            end
            default: bad = 1'b1;
        endcase

        if (bad) begin
            d         = '0;
            d.op      = OP_NONE;
            d.src     = SEL_NONE;
            d.dst     = SEL_NONE;
            d.phase   = PH_DONE;
            d.invalid = 1'b1;
        end else if (d.phase != PH_MODRM && (d.disp != '0 || d.imm != '0)) begin
            d.phase = PH_TAIL;
        end
    end

    // Drive the prefix flag and the decoded record.
    always_comb begin
        pfx_o = pfx_seg_o | pfx_lock_o | pfx_rep_o;
        dec_o = d;
    end

endmodule

// File: rtl/opc_classifier.sv
// Top of the byte-serial classifier: takes prefixes and one opcode,
// posts the classification for one cycle, then stands aside while a
// later stage handles ModR/M and trailing bytes.
// Assumes follow_done is pulsed by the later stage once it has what
// the posted counts asked for; follow_done while ready is ignored.
module opc_classifier
    import opc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [BYTE_W-1:0]   in_byte,
    input  logic                follow_done,
    output logic                byte_taken,
    output logic                out_valid,
    output logic                out_invalid,
    output logic [OP_W-1:0]     out_op,
    output logic [SEL_W-1:0]    out_src,
    output logic [SEL_W-1:0]    out_dst,
    output logic [SIZE_W-1:0]   out_size,
    output logic [1:0]          out_phase,
    output logic [DISP_W-1:0]   out_disp_bytes,
    output logic [IMM_W-1:0]    out_imm_bytes,
    output logic [2:0]          out_seg,
    output logic                out_lock,
    output logic [1:0]          out_rep,
    output logic [CNT_W-1:0]    out_consumed
);

    typedef enum logic {ST_READY, ST_HANDOFF} st_e;

    st_e              st_q;
    dec_t             dec;
    logic             is_pfx;
    logic             pfx_seg, pfx_lock, pfx_rep;
    seg_e             pfx_seg_val;
    rep_e             pfx_rep_val;
    seg_e             cur_seg;
    logic             cur_lock;
    rep_e             cur_rep;
    logic [CNT_W-1:0] cnt_next;
    logic             take_pfx;
    logic             take_opc;

    opc_decode_table u_table (
        .byte_i     (in_byte),
        .dec_o      (dec),
        .pfx_o      (is_pfx),
        .pfx_seg_o  (pfx_seg),
        .pfx_lock_o (pfx_lock),
        .pfx_rep_o  (pfx_rep),
        .seg_o      (pfx_seg_val),
        .rep_o      (pfx_rep_val)
    );

    // Accept strobes: only in the ready state is a byte consumed.
    always_comb begin
        byte_taken = in_valid && (st_q == ST_READY);
        take_pfx   = byte_taken && is_pfx;
        take_opc   = byte_taken && !is_pfx;
    end

    opc_prefix_latch u_prefix (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (take_opc),
        .ld_seg_i  (take_pfx && pfx_seg),
        .ld_lock_i (take_pfx && pfx_lock),
        .ld_rep_i  (take_pfx && pfx_rep),
        .seg_i     (pfx_seg_val),
        .rep_i     (pfx_rep_val),
        .seg_o     (cur_seg),
        .lock_o    (cur_lock),
        .rep_o     (cur_rep)
    );

    opc_byte_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (take_pfx),
        .clear_i (take_opc),
        .next_o  (cnt_next)
    );

    // Hand-off state: wait for the later stage when bytes still follow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_READY;
        end else if (st_q == ST_READY) begin
            if (take_opc && !dec.invalid && dec.phase != PH_DONE) st_q <= ST_HANDOFF;
        end else if (follow_done) begin
            st_q <= ST_READY;
        end
    end

    // Result register: load on the opcode byte, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid      <= 1'b0;
            out_invalid    <= 1'b0;
            out_op         <= OP_NONE;
            out_src        <= SEL_NONE;
            out_dst        <= SEL_NONE;
            out_size       <= '0;
            out_phase      <= PH_DONE;
            out_disp_bytes <= '0;
            out_imm_bytes  <= '0;
            out_seg        <= SEG_NONE;
            out_lock       <= 1'b0;
            out_rep        <= REP_NONE;
            out_consumed   <= '0;
        end else begin
            out_valid <= take_opc;
            if (take_opc) begin
                out_invalid    <= dec.invalid;
                out_op         <= dec.op;
                out_src        <= dec.src;
                out_dst        <= dec.dst;
                out_size       <= dec.size;
                out_phase      <= dec.phase;
                out_disp_bytes <= dec.disp;
                out_imm_bytes  <= dec.imm;
                out_seg        <= cur_seg;
                out_lock       <= cur_lock;
                out_rep        <= cur_rep;
                out_consumed   <= cnt_next;
            end
        end
    end

endmodule

// File: rtl/opc_classifier_chk.sv
// Port-level properties of the classifier, bound onto the top module.
// Assumes rst_n is held low over the first clock edge.
module opc_classifier_chk
    import opc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              byte_taken,
    input logic              out_valid,
    input logic              out_invalid,
    input logic [OP_W-1:0]   out_op,
    input logic [1:0]        out_phase,
    input logic [DISP_W-1:0] out_disp_bytes,
    input logic [CNT_W-1:0]  out_consumed
);

    p_taken_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        byte_taken |-> in_valid);

    p_handoff_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_invalid && out_phase != 2'(PH_DONE)) |-> !byte_taken);

    p_post_follows_take_r12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(byte_taken));

    p_hold_between_posts_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_op) && $stable(out_consumed)));

    p_count_nonzero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_consumed != '0);

    p_invalid_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |-> (out_op == OP_W'(OP_NONE) && out_phase == 2'(PH_DONE)));

    p_modrm_no_disp_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_phase == 2'(PH_MODRM)) |-> out_disp_bytes == '0);

endmodule

bind opc_classifier opc_classifier_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .byte_taken     (byte_taken),
    .out_valid      (out_valid),
    .out_invalid    (out_invalid),
    .out_op         (out_op),
    .out_phase      (out_phase),
    .out_disp_bytes (out_disp_bytes),
    .out_consumed   (out_consumed)
);

// File: tb/opc_classifier_tb.sv
`timescale 1ns/1ps
module opc_classifier_tb;
    import opc_pkg::*;

    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_byte = 8'h00;
    logic             follow_done = 1'b0;
    logic             byte_taken, out_valid, out_invalid, out_lock;
    logic [6:0]       out_op;
    logic [4:0]       out_src, out_dst;
    logic [2:0]       out_size, out_imm_bytes, out_seg;
    logic [1:0]       out_phase, out_disp_bytes, out_rep;
    logic [CNT_W-1:0] out_consumed;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    opc_classifier #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .follow_done(follow_done), .byte_taken(byte_taken), .out_valid(out_valid),
        .out_invalid(out_invalid), .out_op(out_op), .out_src(out_src), .out_dst(out_dst),
        .out_size(out_size), .out_phase(out_phase), .out_disp_bytes(out_disp_bytes),
        .out_imm_bytes(out_imm_bytes), .out_seg(out_seg), .out_lock(out_lock),
        .out_rep(out_rep), .out_consumed(out_consumed)
    );

    task automatic cmp(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Present one byte for one clock; result is visible at the returning negedge.
    task automatic put(logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic post(string tag, op_e op, sel_e s, sel_e d, int sz, phase_e ph,
                        int dsp, int imm, seg_e sg, int lk, rep_e rp, int cnt);
        cmp({tag, " valid"}, int'(out_valid), 1);
        cmp({tag, " invalid"}, int'(out_invalid), 0);
        cmp({tag, " op"}, int'(out_op), int'(op));
        cmp({tag, " src"}, int'(out_src), int'(s));
        cmp({tag, " dst"}, int'(out_dst), int'(d));
        cmp({tag, " size"}, int'(out_size), sz);
        cmp({tag, " phase"}, int'(out_phase), int'(ph));
        cmp({tag, " disp"}, int'(out_disp_bytes), dsp);
        cmp({tag, " imm"}, int'(out_imm_bytes), imm);
        cmp({tag, " seg"}, int'(out_seg), int'(sg));
        cmp({tag, " lock"}, int'(out_lock), lk);
        cmp({tag, " rep"}, int'(out_rep), int'(rp));
        cmp({tag, " consumed"}, int'(out_consumed), cnt);
    endtask

    task automatic release_handoff();
        @(negedge clk);
        follow_done = 1'b1;
        @(negedge clk);
        follow_done = 1'b0;
    endtask

    task automatic t_reset();
        cmp("R1 valid", int'(out_valid), 0);
        cmp("R1 op", int'(out_op), int'(OP_NONE));
        cmp("R1 consumed", int'(out_consumed), 0);
        cmp("R1 seg", int'(out_seg), 0);
        cmp("R1 taken idle", int'(byte_taken), 0);
        @(negedge clk);
        in_valid = 1'b1; in_byte = 8'h90;
        #1 cmp("R1 taken ready", int'(byte_taken), 1);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_alu();
        put(8'h01); post("R3 01", OP_ADD, SEL_REG, SEL_RM, 2, PH_MODRM, 0, 0, SEG_NONE, 0, REP_NONE, 1);
        release_handoff();
        put(8'h2A); post("R3 2A", OP_SUB, SEL_RM, SEL_REG, 1, PH_MODRM, 0, 0, SEG_NONE, 0, REP_NONE, 1);
        release_handoff();
        put(8'h3C); post("R3 3C", OP_CMP, SEL_IMM, SEL_AL, 1, PH_TAIL, 0, 1, SEG_NONE, 0, REP_NONE, 1);
        release_handoff();
        put(8'h0D); post("R3 0D", OP_OR, SEL_IMM, SEL_AX, 2, PH_TAIL, 0, 2, SEG_NONE, 0, REP_NONE, 1);
        release_handoff();
    endtask

    task automatic t_regblocks();
        put(8'h43); post("R4 43", OP_INC, SEL_BX, SEL_BX, 2, PH_DONE, 0, 0, SEG_NONE, 0, REP_NONE, 1);
        put(8'h5E); post("R4 5E", OP_POP, SEL_SI, SEL_SI, 2, PH_DONE, 0, 0, SEG_NONE, 0, REP_NONE, 1);
        put(8'h4F); post("R4 4F", OP_DEC, SEL_DI, SEL_DI, 2, PH_DONE, 0, 0, SEG_NONE, 0, REP_NONE, 1);
    endtask

    task automatic t_branches();
        put(8'h74); post("R5 74", OP_JE, SEL_NONE, SEL_NONE, 0, PH_TAIL, 1, 0, SEG_NONE, 0, REP_NONE, 1);
        release_handoff();
        put(8'hE2); post("R5 E2", OP_LOOP, SEL_NONE, SEL_NONE, 0, PH_TAIL, 1, 0, SEG_NONE, 0, REP_NONE, 1);
        release_handoff();
        put(8'hEB); post("R5 EB", OP_JMPN, SEL_NONE, SEL_NONE, 0, PH_TAIL, 1, 0, SEG_NONE, 0, REP_NONE, 1);
        release_handoff();
        put(8'hE8); post("R5 E8", OP_CALLN, SEL_NONE, SEL_NONE, 2, PH_TAIL, 2, 0, SEG_NONE, 0, REP_NONE, 1);
        release_handoff();
    endtask

    task automatic t_far();
        put(8'h9A); post("R6 9A", OP_CALLF, SEL_IMM, SEL_NONE, 4, PH_TAIL, 0, 4, SEG_NONE, 0, REP_NONE, 1);
        release_handoff();
        put(8'hEA); post("R6 EA", OP_JMPF, SEL_IMM, SEL_NONE, 4, PH_TAIL, 0, 4, SEG_NONE, 0, REP_NONE, 1);
        release_handoff();
    endtask

    task automatic t_movimm();
        put(8'hB4); post("R7 B4", OP_MOV, SEL_IMM, SEL_AH, 1, PH_TAIL, 0, 1, SEG_NONE, 0, REP_NONE, 1);
        release_handoff();
        put(8'hBF); post("R7 BF", OP_MOV, SEL_IMM, SEL_DI, 2, PH_TAIL, 0, 2, SEG_NONE, 0, REP_NONE, 1);
        release_handoff();
    endtask

    task automatic t_shift();
        put(8'hD1); post("R8 D1", OP_GRP_SHIFT, SEL_ONE, SEL_RM, 2, PH_MODRM, 0, 0, SEG_NONE, 0, REP_NONE, 1);
        release_handoff();
        put(8'hD2); post("R8 D2", OP_GRP_SHIFT, SEL_CL, SEL_RM, 1, PH_MODRM, 0, 0, SEG_NONE, 0, REP_NONE, 1);
        release_handoff();
    endtask

    task automatic t_prefix();
        put(8'h26); put(8'hF3); put(8'hA4);
        post("R2 rep seg", OP_MOVS, SEL_NONE, SEL_NONE, 1, PH_DONE, 0, 0, SEG_ES, 0, REP_E, 3);
        put(8'h90);
        post("R10 cleared", OP_NOP, SEL_NONE, SEL_NONE, 0, PH_DONE, 0, 0, SEG_NONE, 0, REP_NONE, 1);
        put(8'hF0); put(8'h86);
        post("R2 lock", OP_XCHG, SEL_RM, SEL_REG, 1, PH_MODRM, 0, 0, SEG_NONE, 1, REP_NONE, 2);
        release_handoff();
        put(8'h2E); put(8'hF2); put(8'h3E); put(8'h8B);
        post("R2 last wins", OP_MOV, SEL_RM, SEL_REG, 2, PH_MODRM, 0, 0, SEG_DS, 0, REP_NE, 4);
        release_handoff();
    endtask

    task automatic t_invalid();
        put(8'hF0); put(8'h60);
        cmp("R9 valid", int'(out_valid), 1);
        cmp("R9 invalid", int'(out_invalid), 1);
        cmp("R9 op", int'(out_op), int'(OP_NONE));
        cmp("R9 phase", int'(out_phase), int'(PH_DONE));
        cmp("R9 consumed", int'(out_consumed), 2);
        put(8'hC3);
        post("R10 after invalid", OP_RETN, SEL_NONE, SEL_NONE, 2, PH_DONE, 0, 0, SEG_NONE, 0, REP_NONE, 1);
    endtask

    task automatic t_handoff();
        put(8'h88);
        post("R11 post", OP_MOV, SEL_REG, SEL_RM, 1, PH_MODRM, 0, 0, SEG_NONE, 0, REP_NONE, 1);
        @(negedge clk);
        in_valid = 1'b1; in_byte = 8'h26;
        #1 cmp("R11 not taken", int'(byte_taken), 0);
        @(negedge clk);
        in_byte = 8'hF0;
        cmp("R11 no post", int'(out_valid), 0);
        @(negedge clk);
        in_valid = 1'b0;
        cmp("R11 no post 2", int'(out_valid), 0);
        release_handoff();
        put(8'h90);
        post("R11 ignored", OP_NOP, SEL_NONE, SEL_NONE, 0, PH_DONE, 0, 0, SEG_NONE, 0, REP_NONE, 1);
        @(negedge clk);
        cmp("R12 one pulse", int'(out_valid), 0);
        cmp("R12 hold", int'(out_op), int'(OP_NOP));
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 17; i++) put(8'h36);
        put(8'h90);
        post("R12 saturate", OP_NOP, SEL_NONE, SEL_NONE, 0, PH_DONE, 0, 0, SEG_SS, 0, REP_NONE, 15);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_alu();
        t_regblocks();
        t_branches();
        t_far();
        t_movimm();
        t_shift();
        t_prefix();
        t_invalid();
        t_handoff();
        t_saturate();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule